// File: doc/BRIEF.md
# Set-Associative Write-Back Cache Controller

This block is a parameterised cache placed between a processor that reads and writes single words and a backing memory that moves whole blocks. Each processor word address is split into three fields. The low field picks a word inside a block, the middle field selects a set, and the high field is the tag. The tags of all ways in the selected set are compared at once. A valid match is a hit and is served in the same cycle the request is presented.

On a miss the processor is stalled. A victim way is chosen: the lowest-numbered empty way if one exists, otherwise the way used least recently. A dirty victim is first copied back to memory, and then the missing block is fetched. After the refill the request is retried as a hit, so a write miss allocates the line and marks it dirty. Write hits stay in the cache and only set the line's dirty flag. The associativity parameter covers direct-mapped (one way) through fully associative (one set). Two counters report how many accesses hit on first lookup and how many missed.

Top module: `cache_ctrl`

## Requirements
- R1: The word offset is the lowest `log2(LINE_WORDS)` address bits, the set index the next `log2(NUM_LINES/WAYS)` bits and the tag the rest. One refill fetches the whole block, with offset 0 in the least significant `DATA_W` bits of the memory block bus, so every word of a freshly filled block then hits with the memory's value.
- R2: A read of a resident word raises `cpu_ready` in the same cycle as `cpu_req` and returns the stored word, with no memory request.
- R3: While the selected set still holds an empty way, a miss fills an empty way (the lowest-numbered) and never evicts a valid line.
- R4: When every way of the set is valid, the victim is the way least recently read or written. Every hit and every retried fill refresh recency.
- R5: A write hit changes only the cached word, issues no memory traffic and marks the line dirty.
- R6: A dirty victim is written back as one block (`mem_we`=1) to its own block address, and the write is acknowledged before the refill read starts. The block carries every word modified while cached.
- R7: A clean victim is dropped without a write: the miss issues exactly one block read.
- R8: `mem_req` with its `mem_we` and `mem_addr` stays steady until `mem_ack`. `cpu_ready` stays low from the miss until the cycle after the refill acknowledgment, when the retried access completes.
- R9: A write miss refills the block, then applies the write as a hit. The new value is read back from the cache, and memory receives it only when the line is evicted.
- R10: Reset empties every line, restores recency order and clears both counters.
- R11: `miss_count` rises by one per miss. `hit_count` rises by one per access that hits on its first lookup, and not for the retry after a refill. On the default 2-way, 4-line geometry the block trace 0, 2, 0, 4, 2 gives miss, miss, hit, miss, miss.
- R12: On the same geometry, starting from reset, the block trace 0, 2, 0, 1, 4, 0, 2, 3, 5, 4 ends with `hit_count`=2 and `miss_count`=8.
- R13: With `WAYS`=1 each block has a single home (trace 0, 2, 0, 4, 2 gives M, M, H, M, H on 4 lines). With `WAYS`=`NUM_LINES` there is no index field and any block may occupy any line, with LRU over all lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid while `cpu_ready` |
| cpu_ready | output | 1 | Access completes at this clock edge |
| mem_req | output | 1 | Block transfer request |
| mem_we | output | 1 | 1 = block write-back, 0 = block refill |
| mem_addr | output | ADDR_W-log2(LINE_WORDS) | Block address |
| mem_wdata | output | LINE_WORDS*DATA_W | Write-back block |
| mem_rdata | input | LINE_WORDS*DATA_W | Refill block, sampled with `mem_ack` |
| mem_ack | input | 1 | One-cycle transfer completion |
| hit_count | output | CNT_W | First-lookup hits since reset |
| miss_count | output | CNT_W | Misses since reset |

## Verification
The assertions assume a processor that keeps `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady from a request until `cpu_ready`. They also assume a memory that answers each request with exactly one `mem_ack` pulse. The bench drives requests only through one task that holds all processor inputs until completion. Its memory model acknowledges each request once, after a fixed latency, and drops the acknowledgment in the next cycle. Three instances (2-way, direct-mapped and fully associative) share that stimulus, so every geometry sees only legal traffic.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_LOOKUP = 2'd0,
    ST_WBACK  = 2'd1,
    ST_FILL   = 2'd2
  } cache_state_e;
endpackage

// File: rtl/cache_way_match.sv
module cache_way_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
  input  logic [WAYS-1:0]            set_valid,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = set_valid[w] && (set_tags[w] == tag);
  end

  assign hit = |match;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/cache_victim.sv
module cache_victim #(
  parameter int WAYS = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]            set_valid,
  input  logic [WAYS-1:0][WAY_W-1:0] set_age,
  output logic [WAY_W-1:0]           victim
);
  always_comb begin
    victim = '0;
    // oldest way first, then the lowest empty way overrides it
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (set_age[w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!set_valid[w]) victim = WAY_W'(w);
    end
  end
endmodule

// File: rtl/cache_lru_update.sv
module cache_lru_update #(
  parameter int WAYS = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][WAY_W-1:0] age_in,
  input  logic [WAY_W-1:0]           touched,
  output logic [WAYS-1:0][WAY_W-1:0] age_out
);
  logic [WAY_W-1:0] ref_age;

  assign ref_age = age_in[touched];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == touched)     age_out[w] = '0;
      else if (age_in[w] < ref_age) age_out[w] = age_in[w] + WAY_W'(1);
      else                          age_out[w] = age_in[w];
    end
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int LINE_WORDS = 2,
  parameter int NUM_LINES  = 4,
  parameter int WAYS       = 2,
  parameter int CNT_W      = 16,
  localparam int SETS      = NUM_LINES / WAYS,
  localparam int OFF_BITS  = $clog2(LINE_WORDS),
  localparam int IDX_BITS  = $clog2(SETS),
  localparam int TAG_W     = ADDR_W - OFF_BITS - IDX_BITS,
  localparam int BLK_W     = ADDR_W - OFF_BITS,
  localparam int LINE_BITS = LINE_WORDS * DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [DATA_W-1:0]    cpu_wdata,
  output logic [DATA_W-1:0]    cpu_rdata,
  output logic                 cpu_ready,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [BLK_W-1:0]     mem_addr,
  output logic [LINE_BITS-1:0] mem_wdata,
  input  logic [LINE_BITS-1:0] mem_rdata,
  input  logic                 mem_ack,
  output logic [CNT_W-1:0]     hit_count,
  output logic [CNT_W-1:0]     miss_count
);
  localparam int SET_W = (IDX_BITS > 0) ? IDX_BITS : 1;
  localparam int OFF_W = (OFF_BITS > 0) ? OFF_BITS : 1;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta_q} <= 2'b00;
    else        {rst_sync_n, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  // address fields
  logic [SET_W-1:0] set_idx;
  logic [OFF_W-1:0] word_off;
  logic [TAG_W-1:0] req_tag;
  assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];

  if (IDX_BITS > 0) begin : g_idx
    assign set_idx = cpu_addr[OFF_BITS +: IDX_BITS];
  end else begin : g_noidx
    assign set_idx = '0;
  end

  if (OFF_BITS > 0) begin : g_off
    assign word_off = cpu_addr[0 +: OFF_BITS];
  end else begin : g_nooff
    assign word_off = '0;
  end

  // line state
  logic [SETS-1:0][WAYS-1:0]                valid_q, dirty_q;
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0]     age_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]     tag_q;
  logic [SETS-1:0][WAYS-1:0][LINE_BITS-1:0] data_q;

  cache_state_e     state_q, state_d;
  logic [WAY_W-1:0] victim_q, hit_way, victim_way;
  logic             retry_q, retry_d, hit;
  logic [CNT_W-1:0] hit_cnt_d, miss_cnt_d;
  logic [WAYS-1:0][WAY_W-1:0] age_upd;
  logic             access_done, miss_start, fill_done, wr_hit, victim_dirty;
  logic [BLK_W-1:0] wb_blk;

  cache_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .set_tags (tag_q[set_idx]),
    .set_valid(valid_q[set_idx]),
    .tag      (req_tag),
    .hit      (hit),
    .hit_way  (hit_way)
  );

  cache_victim #(.WAYS(WAYS)) u_victim (
    .set_valid(valid_q[set_idx]),
    .set_age  (age_q[set_idx]),
    .victim   (victim_way)
  );

  cache_lru_update #(.WAYS(WAYS)) u_lru (
    .age_in (age_q[set_idx]),
    .touched(hit_way),
    .age_out(age_upd)
  );

  assign access_done  = (state_q == ST_LOOKUP) && cpu_req && hit;
  assign miss_start   = (state_q == ST_LOOKUP) && cpu_req && !hit;
  assign fill_done    = (state_q == ST_FILL) && mem_ack;
  assign wr_hit       = access_done && cpu_we;
  assign victim_dirty = valid_q[set_idx][victim_way] && dirty_q[set_idx][victim_way];

  if (IDX_BITS > 0) begin : g_wb_idx
    assign wb_blk = {tag_q[set_idx][victim_q], set_idx};
  end else begin : g_wb_noidx
    assign wb_blk = tag_q[set_idx][victim_q];
  end

  // next-state logic
  always_comb begin
    state_d    = state_q;
    retry_d    = retry_q;
    hit_cnt_d  = hit_count;
    miss_cnt_d = miss_count;
    case (state_q)
      ST_LOOKUP: if (miss_start) state_d = victim_dirty ? ST_WBACK : ST_FILL;
      ST_WBACK:  if (mem_ack) state_d = ST_FILL;
      ST_FILL:   if (mem_ack) state_d = ST_LOOKUP;
      default:   state_d = ST_LOOKUP;
    endcase
    if (miss_start) miss_cnt_d = miss_count + CNT_W'(1);
    if (access_done && !retry_q) hit_cnt_d = hit_count + CNT_W'(1);
    if (fill_done) retry_d = 1'b1;
    else if (access_done) retry_d = 1'b0;
  end

  // control and state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q    <= ST_LOOKUP;
      retry_q    <= 1'b0;
      victim_q   <= '0;
      hit_count  <= '0;
      miss_count <= '0;
      valid_q    <= '0;
      dirty_q    <= '0;
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else begin
      state_q    <= state_d;
      retry_q    <= retry_d;
      hit_count  <= hit_cnt_d;
      miss_count <= miss_cnt_d;
      if (miss_start) victim_q <= victim_way;
      if (fill_done) begin
        valid_q[set_idx][victim_q] <= 1'b1;
        dirty_q[set_idx][victim_q] <= 1'b0;
      end
      if (wr_hit) dirty_q[set_idx][hit_way] <= 1'b1;
      if (access_done) age_q[set_idx] <= age_upd;
    end
  end

  // tag and data arrays, no reset
  always_ff @(posedge clk) begin
    if (fill_done) begin
      tag_q[set_idx][victim_q]  <= req_tag;
      data_q[set_idx][victim_q] <= mem_rdata;
    end else if (wr_hit) begin
      data_q[set_idx][hit_way][word_off*DATA_W +: DATA_W] <= cpu_wdata;
    end
  end

  assign cpu_ready = access_done;
  assign cpu_rdata = data_q[set_idx][hit_way][word_off*DATA_W +: DATA_W];
  assign mem_req   = (state_q != ST_LOOKUP);
  assign mem_we    = (state_q == ST_WBACK);
  assign mem_addr  = (state_q == ST_WBACK) ? wb_blk : cpu_addr[ADDR_W-1:OFF_BITS];
  assign mem_wdata = data_q[set_idx][victim_q];
endmodule

// File: rtl/cache_ctrl_chk.sv
module cache_ctrl_chk #(
  parameter int ADDR_W     = 8,
  parameter int LINE_WORDS = 2,
  parameter int CNT_W      = 16,
  localparam int BLK_W     = ADDR_W - $clog2(LINE_WORDS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req,
  input logic             cpu_ready,
  input logic             mem_req,
  input logic             mem_we,
  input logic [BLK_W-1:0] mem_addr,
  input logic             mem_ack,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count
);
  // R8: a transfer stays requested until acknowledged
  p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req);

  // R8: direction and block address steady while waiting
  p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> $stable(mem_addr) && $stable(mem_we));

  // R8: the processor is never released during a memory transfer
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  // R6: an acknowledged write-back is followed by the refill read
  p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> mem_req && !mem_we);

  // R11: a stalled lookup counts exactly one miss
  p_miss_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_ready && !mem_req |=> miss_count == $past(miss_count) + CNT_W'(1));

  // R11: the hit counter only moves after a completed access
  p_hit_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hit_count != $past(hit_count) |-> $past(cpu_ready) &&
      (hit_count == $past(hit_count) + CNT_W'(1)));
endmodule

bind cache_ctrl cache_ctrl_chk #(
  .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/tb_cache_ctrl.sv
module tb_cache_ctrl;
  localparam int NK = 3;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic        req   [NK];
  logic        we    [NK];
  logic [7:0]  addr  [NK];
  logic [15:0] wdata [NK];
  logic [15:0] rdata [NK];
  logic        ready [NK];
  logic        mreq  [NK];
  logic        mwe   [NK];
  logic [6:0]  maddr [NK];
  logic [31:0] mwdata[NK];
  logic [31:0] mrdata[NK];
  logic        mack  [NK];
  logic [15:0] hits  [NK];
  logic [15:0] misses[NK];

  logic [15:0] mem   [NK][256];
  int          mcnt  [NK];
  int          op_cnt[NK];
  logic [7:0]  op_log[NK];

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // instance 0: 2-way, 1: direct-mapped, 2: fully associative
  for (genvar k = 0; k < NK; k++) begin : g
    localparam int WK = (k == 0) ? 2 : ((k == 1) ? 1 : 4);
    cache_ctrl #(.ADDR_W(8), .DATA_W(16), .LINE_WORDS(2), .NUM_LINES(4),
                 .WAYS(WK), .CNT_W(16)) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(req[k]), .cpu_we(we[k]), .cpu_addr(addr[k]), .cpu_wdata(wdata[k]),
      .cpu_rdata(rdata[k]), .cpu_ready(ready[k]),
      .mem_req(mreq[k]), .mem_we(mwe[k]), .mem_addr(maddr[k]),
      .mem_wdata(mwdata[k]), .mem_rdata(mrdata[k]), .mem_ack(mack[k]),
      .hit_count(hits[k]), .miss_count(misses[k])
    );
  end

  always_comb begin
    for (int k = 0; k < NK; k++)
      mrdata[k] = {mem[k][{maddr[k], 1'b1}], mem[k][{maddr[k], 1'b0}]};
  end

  // memory model: acknowledge on the third cycle of a request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NK; k++) begin
        mack[k] <= 1'b0;
        mcnt[k] <= 0;
      end
    end else begin
      for (int k = 0; k < NK; k++) begin
        mack[k] <= 1'b0;
        if (mreq[k] && !mack[k]) begin
          if (mcnt[k] == 2) begin
            mack[k]   <= 1'b1;
            mcnt[k]   <= 0;
            op_cnt[k] <= op_cnt[k] + 1;
            op_log[k] <= {op_log[k][6:0], mwe[k]};
            if (mwe[k]) begin
              mem[k][{maddr[k], 1'b0}] <= mwdata[k][15:0];
              mem[k][{maddr[k], 1'b1}] <= mwdata[k][31:16];
            end
          end else begin
            mcnt[k] <= mcnt[k] + 1;
          end
        end
      end
    end
  end

  function automatic logic [15:0] init_val(input int a);
    return 16'h5000 | 16'(a);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int k = 0; k < NK; k++) begin
      req[k] = 1'b0; we[k] = 1'b0; addr[k] = '0; wdata[k] = '0;
      op_cnt[k] = 0; op_log[k] = '0;
      for (int a = 0; a < 256; a++) mem[k][a] = init_val(a);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // one access; h = hit on first lookup, lat = stalled cycles
  task automatic access(input int k, input logic w, input logic [7:0] a,
                        input logic [15:0] d, output logic h,
                        output logic [15:0] rd, output int lat);
    @(negedge clk);
    req[k] = 1'b1; we[k] = w; addr[k] = a; wdata[k] = d;
    #1;
    h   = ready[k];
    lat = 0;
    while (!ready[k]) begin
      @(negedge clk);
      #1;
      lat++;
    end
    rd = rdata[k];
    @(posedge clk);
    #1;
    req[k] = 1'b0;
  endtask

  initial begin
    logic        h;
    logic [15:0] rd;
    int          lat, ops;
    int          t1 [5] = '{0, 2, 0, 4, 2};
    int          t2 [10] = '{0, 2, 0, 1, 4, 0, 2, 3, 5, 4};
    bit          e2w[5] = '{0, 0, 1, 0, 0};
    bit          e1w[5] = '{0, 0, 1, 0, 1};

    do_reset();
    // R10: counters clear after reset
    for (int k = 0; k < NK; k++) begin
      chk("R10 hit_count after reset", hits[k], 0);
      chk("R10 miss_count after reset", misses[k], 0);
    end

    // R11 / R13: trace 0,2,0,4,2 on each geometry
    for (int i = 0; i < 5; i++) begin
      access(0, 1'b0, 8'(t1[i] * 2), 16'h0, h, rd, lat);
      chk($sformatf("R11 2-way trace step %0d hit", i), h, e2w[i]);
      chk($sformatf("R1 2-way trace step %0d data", i), rd, init_val(t1[i] * 2));
      access(1, 1'b0, 8'(t1[i] * 2), 16'h0, h, rd, lat);
      chk($sformatf("R13 direct trace step %0d hit", i), h, e1w[i]);
      access(2, 1'b0, 8'(t1[i] * 2), 16'h0, h, rd, lat);
      chk($sformatf("R13 full trace step %0d hit", i), h, e1w[i]);
    end
    chk("R11 2-way hit_count", hits[0], 1);
    chk("R11 2-way miss_count", misses[0], 4);
    chk("R13 direct hit_count", hits[1], 2);
    chk("R13 direct miss_count", misses[1], 3);

    // R10: reset empties lines
    do_reset();
    access(0, 1'b0, 8'd0, 16'h0, h, rd, lat);
    chk("R10 previously cached block misses after reset", h, 0);

    // R12: long trace
    do_reset();
    for (int i = 0; i < 10; i++) access(0, 1'b0, 8'(t2[i] * 2), 16'h0, h, rd, lat);
    chk("R12 hit_count", hits[0], 2);
    chk("R12 miss_count", misses[0], 8);

    // R3 / R13 / R4: fully associative fill and LRU
    do_reset();
    for (int b = 0; b < 4; b++) access(2, 1'b0, 8'(b * 2 * 2), 16'h0, h, rd, lat);
    for (int b = 0; b < 4; b++) begin
      access(2, 1'b0, 8'(b * 2 * 2), 16'h0, h, rd, lat);
      chk($sformatf("R3 empty ways filled first, block %0d kept", b * 2), h, 1);
    end
    access(2, 1'b0, 8'd0, 16'h0, h, rd, lat);       // block 0 most recent
    access(2, 1'b0, 8'd16, 16'h0, h, rd, lat);      // block 8 evicts block 2
    chk("R4 new block misses", h, 0);
    access(2, 1'b0, 8'd0, 16'h0, h, rd, lat);
    chk("R4 recently used block kept", h, 1);
    access(2, 1'b0, 8'd4, 16'h0, h, rd, lat);
    chk("R4 LRU block evicted", h, 0);

    // data path on the 2-way instance
    do_reset();
    access(0, 1'b1, 8'h10, 16'hBEEF, h, rd, lat);
    chk("R9 write miss", h, 0);
    chk("R7 empty-way refill is one read", op_cnt[0], 1);
    chk("R8 clean miss stall cycles", lat, 5);
    access(0, 1'b0, 8'h10, 16'h0, h, rd, lat);
    chk("R9 allocated word hit", h, 1);
    chk("R9 allocated word value", rd, 16'hBEEF);
    chk("R9 memory not yet written", mem[0][8'h10], init_val(8'h10));
    access(0, 1'b0, 8'h11, 16'h0, h, rd, lat);
    chk("R1 neighbour word hit", h, 1);
    chk("R1 neighbour word value", rd, init_val(8'h11));
    chk("R2 hit without stall", lat, 0);
    ops = op_cnt[0];
    access(0, 1'b1, 8'h11, 16'h1234, h, rd, lat);
    chk("R5 write hit", h, 1);
    chk("R5 no memory traffic", op_cnt[0], ops);
    chk("R5 memory unchanged", mem[0][8'h11], init_val(8'h11));
    access(0, 1'b0, 8'h11, 16'h0, h, rd, lat);
    chk("R5 written value read back", rd, 16'h1234);
    access(0, 1'b0, 8'h20, 16'h0, h, rd, lat);
    chk("R3 second way fill is a miss", h, 0);
    access(0, 1'b0, 8'h20, 16'h0, h, rd, lat);
    ops = op_cnt[0];
    access(0, 1'b0, 8'h30, 16'h0, h, rd, lat);
    chk("R6 dirty eviction makes two transfers", op_cnt[0] - ops, 2);
    chk("R6 write-back precedes refill", op_log[0][1:0], 2'b10);
    chk("R8 dirty miss stall cycles", lat, 9);
    chk("R6 written back word 0", mem[0][8'h10], 16'hBEEF);
    chk("R6 written back word 1", mem[0][8'h11], 16'h1234);
    chk("R6 refill data", rd, init_val(8'h30));
    ops = op_cnt[0];
    access(0, 1'b0, 8'h10, 16'h0, h, rd, lat);
    chk("R7 clean eviction is one read", op_cnt[0] - ops, 1);
    chk("R7 last transfer is a read", op_log[0][0], 0);
    chk("R6 data restored from memory", rd, 16'hBEEF);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule